// File: doc/BRIEF.md
# I2C Address Sweeper

This block is a small I2C master whose only job is to find out which 7-bit addresses on a bus answer. When `start_i` is seen while the block is idle, it clears its presence map and walks through the legal address range in ascending order. For each address it issues a START and the address byte with the direction bit at 0 (write), samples the acknowledge slot, and ends with a STOP. Each address that is pulled low in the acknowledge slot gets a 1 at its position in the map.

The map is 128 bits wide, one bit per 7-bit address. It can be read as 16 bytes: byte `a >> 3`, bit `a & 7` holds address `a`, which is simply `map_o[a]`. SCL and SDA are open-drain. An output at 1 pulls the line low and an output at 0 releases it. The SDA level is read back on `sda_i` through a two-flop synchronizer. Each bit period is four quarter periods of `QTR_CYCLES` clocks.

`start_i`, `busy_o` and `done_o` are plain control and status pins. `map_o` is a level output, not a stream, so it has no handshake and no back-pressure. It is valid whenever `busy_o` is low after the first sweep.

Top module: `i2c_addr_sweeper`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `map_o` is all zero, and `scl_oe_o` and `sda_oe_o` are 0. Both lines stay released whenever `busy_o` is 0.
- R2: A `start_i` sampled high while idle raises `busy_o` on the next cycle. In that same cycle `map_o` reads all zero.
- R3: One sweep probes every address from 0x01 to 0x77 exactly once, in ascending order. Address 0x00 and addresses 0x78 to 0x7F never appear on the bus.
- R4: Each probe opens with a START (SDA falls while SCL is high). It then sends eight bits MSB first: the seven address bits, then a direction bit of 0.
- R5: Every probe ends with a STOP (SDA rises while SCL is high), whether or not the address was acknowledged.
- R6: If SDA is low during the acknowledge slot of address `a`, `map_o[a]` (byte `a>>3`, bit `a&7`) ends the sweep at 1. Otherwise it ends the sweep at 0.
- R7: `map_o[0]` and `map_o[127:120]` always read 0, even if a device would acknowledge those addresses.
- R8: `done_o` is high for exactly one cycle, after the STOP of the probe to 0x77. `busy_o` is 0 in that cycle.
- R9: While idle, and without a new start, `map_o` holds its value.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. The sweep neither restarts nor clears the map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sweep when the block is idle |
| busy_o | output | 1 | High while a sweep is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |
| map_o | output | 128 | Presence map; bit `a` is address `a` |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Faults in the address counter show at the ports during the next probe. A skipped, repeated or out-of-range address shows up in the address byte on SDA, and a direction bit of 1 shows up there too. A probe engine stuck mid-frame shows as a missing STOP on the bus and as `done_o` never arriving. A wrong map index or a missed clear only shows in `map_o` at `done_o`. The bench therefore compares the whole map against the responder set at the end of every sweep. It also checks the map on the cycle after start, where any stale bit shows.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [1:0] {
    PE_IDLE,
    PE_START,
    PE_BITS,
    PE_STOP
  } probe_state_t;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_LAUNCH,
    SW_WAIT
  } sweep_state_t;

endpackage

// File: rtl/i2cs_tick_gen.sv
module i2cs_tick_gen #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(QTR_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt == LAST_CNT) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cs_probe_engine.sv
module i2cs_probe_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sda_i,
  output logic              active_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              done_o,
  output logic              ack_o
);
  localparam int FRAME_W = ADDR_W + 1;
  localparam int BCW     = $clog2(FRAME_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(FRAME_W);

  probe_state_t       state;
  logic [1:0]         ph;
  logic [FRAME_W-1:0] shreg;
  logic [BCW-1:0]     bit_cnt;
  logic               scl_low;
  logic               sda_low;
  logic               ack_q;
  logic               sda_s1;
  logic               sda_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_i;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PE_IDLE;
      ph      <= 2'd0;
      shreg   <= '0;
      bit_cnt <= '0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      ack_q   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        PE_IDLE: begin
          if (go_i) begin
            shreg   <= {addr_i, 1'b0};
            bit_cnt <= '0;
            ack_q   <= 1'b0;
            ph      <= 2'd0;
            state   <= PE_START;
          end
        end
        PE_START: begin
          if (tick_i) begin
            case (ph)
              2'd0: begin scl_low <= 1'b0; sda_low <= 1'b0; end
              2'd1: sda_low <= 1'b1;
              2'd2: scl_low <= 1'b1;
              default: state <= PE_BITS;
            endcase
            ph <= ph + 2'd1;
          end
        end
        PE_BITS: begin
          if (tick_i) begin
            case (ph)
              2'd0: sda_low <= (bit_cnt == ACK_SLOT) ? 1'b0 : ~shreg[FRAME_W-1];
              2'd1: scl_low <= 1'b0;
              2'd2: if (bit_cnt == ACK_SLOT) ack_q <= ~sda_s2;
              default: begin
                scl_low <= 1'b1;
                shreg   <= shreg << 1;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == ACK_SLOT) state <= PE_STOP;
              end
            endcase
            ph <= ph + 2'd1;
          end
        end
        default: begin
          if (tick_i) begin
            case (ph)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin
                state  <= PE_IDLE;
                done_o <= 1'b1;
              end
            endcase
            ph <= ph + 2'd1;
          end
        end
      endcase
    end
  end

  assign active_o = (state != PE_IDLE);
  assign scl_oe_o = scl_low;
  assign sda_oe_o = sda_low;
  assign ack_o    = ack_q;
endmodule

// File: rtl/i2cs_presence_map.sv
module i2cs_presence_map #(
  parameter int ADDR_W     = 7,
  parameter int FIRST_ADDR = 1,
  parameter int LAST_ADDR  = 119
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   set_i,
  input  logic [ADDR_W-1:0]      idx_i,
  output logic [(1<<ADDR_W)-1:0] map_o
);
  localparam int MAP_W     = 1 << ADDR_W;
  localparam int MAP_BYTES = MAP_W / 8;

  for (genvar g = 0; g < MAP_BYTES; g++) begin : g_byte
    for (genvar b = 0; b < 8; b++) begin : g_bit
      localparam int POS = g * 8 + b;
      if (POS >= FIRST_ADDR && POS <= LAST_ADDR) begin : g_live
        logic hit;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)
            hit <= 1'b0;
          else if (clear_i)
            hit <= 1'b0;
          else if (set_i && idx_i == ADDR_W'(POS))
            hit <= 1'b1;
        end
        assign map_o[POS] = hit;
      end else begin : g_dead
        assign map_o[POS] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_addr_sweeper.sv
module i2c_addr_sweeper
  import i2cs_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int FIRST_ADDR = 1,
  parameter int LAST_ADDR  = 119,
  parameter int QTR_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [(1<<ADDR_W)-1:0] map_o,
  input  logic                   sda_i,
  output logic                   scl_oe_o,
  output logic                   sda_oe_o
);
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);

  sweep_state_t      sw_state;
  logic [ADDR_W-1:0] cur_addr;
  logic              go;
  logic              probe_active;
  logic              probe_done;
  logic              probe_ack;
  logic              tick;
  logic              map_clear;
  logic              map_set;

  assign go        = (sw_state == SW_LAUNCH);
  assign map_clear = (sw_state == SW_IDLE) && start_i;
  assign map_set   = (sw_state == SW_WAIT) && probe_done && probe_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_state <= SW_IDLE;
      cur_addr <= FIRST_A;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (sw_state)
        SW_IDLE: begin
          if (start_i) begin
            busy_o   <= 1'b1;
            cur_addr <= FIRST_A;
            sw_state <= SW_LAUNCH;
          end
        end
        SW_LAUNCH: sw_state <= SW_WAIT;
        default: begin
          if (probe_done) begin
            if (cur_addr == LAST_A) begin
              busy_o   <= 1'b0;
              done_o   <= 1'b1;
              sw_state <= SW_IDLE;
            end else begin
              cur_addr <= cur_addr + 1'b1;
              sw_state <= SW_LAUNCH;
            end
          end
        end
      endcase
    end
  end

  i2cs_tick_gen #(.QTR_CYCLES(QTR_CYCLES)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (probe_active),
    .tick_o (tick)
  );

  i2cs_probe_engine #(.ADDR_W(ADDR_W)) i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .go_i     (go),
    .addr_i   (cur_addr),
    .sda_i    (sda_i),
    .active_o (probe_active),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o),
    .done_o   (probe_done),
    .ack_o    (probe_ack)
  );

  i2cs_presence_map #(
    .ADDR_W     (ADDR_W),
    .FIRST_ADDR (FIRST_ADDR),
    .LAST_ADDR  (LAST_ADDR)
  ) i_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (map_clear),
    .set_i   (map_set),
    .idx_i   (cur_addr),
    .map_o   (map_o)
  );
endmodule

// File: rtl/i2cs_sweep_checker.sv
module i2cs_sweep_checker #(
  parameter int ADDR_W     = 7,
  parameter int FIRST_ADDR = 1,
  parameter int LAST_ADDR  = 119
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic [(1<<ADDR_W)-1:0] map_o,
  input logic                   scl_oe_o,
  input logic                   sda_oe_o
);
  localparam int MAP_W = 1 << ADDR_W;

  function automatic logic [MAP_W-1:0] legal_mask();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAP_W; i++)
      if (i >= FIRST_ADDR && i <= LAST_ADDR) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [MAP_W-1:0] LEGAL = legal_mask();

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_oe_o && !sda_oe_o)); // R1
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (map_o == '0)); // R2
  AST_UNPROBED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (map_o & ~LEGAL) == '0); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(map_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ((map_o & $past(map_o)) == $past(map_o))); // R10
endmodule

bind i2c_addr_sweeper i2cs_sweep_checker #(
  .ADDR_W     (ADDR_W),
  .FIRST_ADDR (FIRST_ADDR),
  .LAST_ADDR  (LAST_ADDR)
) i_sweep_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .map_o    (map_o),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o)
);

// File: tb/test_i2c_addr_sweeper.sv
module test_i2c_addr_sweeper;
  localparam int CLK_PERIOD = 10;
  localparam int LAST_A     = 119;
  localparam int NPROBES    = 119;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         busy_o;
  logic         done_o;
  logic [127:0] map_o;
  logic         scl_oe_o;
  logic         sda_oe_o;
  logic         slave_pull = 1'b0;
  logic         scl_bus;
  logic         sda_bus;

  int n_checks = 0;
  int n_fails  = 0;

  logic [127:0] present = '0;

  // bus monitor state
  int        probe_cnt, start_cnt, stop_cnt, order_err, rw_err, range_err;
  int        first_seen, last_seen, bitcnt;
  logic [7:0] rx_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = ~scl_oe_o;
  assign sda_bus = ~(sda_oe_o | slave_pull);

  i2c_addr_sweeper i_i2c_addr_sweeper (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .map_o    (map_o),
    .sda_i    (sda_bus),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  // responder and protocol monitor
  always @(negedge sda_bus) begin
    if (scl_bus === 1'b1 && rst_n) begin
      start_cnt = start_cnt + 1;
      bitcnt    = 0;
      rx_byte   = '0;
    end
  end

  always @(posedge sda_bus) begin
    if (scl_bus === 1'b1 && rst_n) stop_cnt = stop_cnt + 1;
  end

  always @(posedge scl_bus) begin
    if (rst_n) begin
      if (bitcnt < 8) begin
        rx_byte = {rx_byte[6:0], sda_bus};
        bitcnt  = bitcnt + 1;
        if (bitcnt == 8) begin
          probe_cnt = probe_cnt + 1;
          if (rx_byte[0] !== 1'b0) rw_err = rw_err + 1;
          if (rx_byte[7:1] == 7'd0 || int'(rx_byte[7:1]) > LAST_A) range_err = range_err + 1;
          if (first_seen < 0) first_seen = int'(rx_byte[7:1]);
          else if (int'(rx_byte[7:1]) != last_seen + 1) order_err = order_err + 1;
          last_seen = int'(rx_byte[7:1]);
        end
      end else if (bitcnt == 8) begin
        bitcnt = 9;
      end
    end
  end

  always @(negedge scl_bus) begin
    if (bitcnt == 8) slave_pull = present[rx_byte[7:1]] & ~rx_byte[0];
    else if (bitcnt == 9) begin
      slave_pull = 1'b0;
      bitcnt     = 10;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_map(input logic [127:0] resp);
    logic [127:0] m;
    m = '0;
    for (int a = 1; a <= LAST_A; a++) m[a] = resp[a];
    return m;
  endfunction

  task automatic clear_monitor();
    probe_cnt = 0; start_cnt = 0; stop_cnt = 0;
    order_err = 0; rw_err = 0; range_err = 0;
    first_seen = -1; last_seen = -1; bitcnt = 10;
  endtask

  // launch a sweep, checks R2, returns after done_o seen; optional mid-sweep start
  task automatic run_sweep(input bit poke_mid);
    clear_monitor();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", 128'(busy_o), 128'd1);
    check(map_o === '0, "R2 map cleared", map_o, '0);
    if (poke_mid) begin
      repeat (6000) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_o !== 1'b1) @(negedge clk);
    check(busy_o === 1'b0, "R8 busy low with done", 128'(busy_o), 128'd0);
    @(negedge clk);
    check(done_o === 1'b0, "R8 done one cycle", 128'(done_o), 128'd0);
  endtask

  task automatic check_bus(input string tag);
    check(probe_cnt == NPROBES, {"R3 probe count ", tag}, 128'(probe_cnt), 128'(NPROBES));
    check(order_err == 0 && first_seen == 1 && last_seen == LAST_A,
          {"R3 order/endpoints ", tag}, 128'(order_err), 128'd0);
    check(range_err == 0, {"R3 out of range ", tag}, 128'(range_err), 128'd0);
    check(rw_err == 0, {"R4 direction bit ", tag}, 128'(rw_err), 128'd0);
    check(start_cnt == NPROBES, {"R4 start count ", tag}, 128'(start_cnt), 128'(NPROBES));
    check(stop_cnt == NPROBES, {"R5 stop count ", tag}, 128'(stop_cnt), 128'(NPROBES));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 reset status", {busy_o, done_o}, '0);
    check(map_o === '0, "R1 reset map", map_o, '0);
    check(scl_oe_o === 1'b0 && sda_oe_o === 1'b0, "R1 lines released",
          {scl_oe_o, sda_oe_o}, '0);
  endtask

  task automatic t_sparse();
    present = '0;
    present[8'h00] = 1'b1; present[8'h01] = 1'b1; present[8'h08] = 1'b1;
    present[8'h10] = 1'b1; present[8'h3C] = 1'b1; present[8'h50] = 1'b1;
    present[8'h77] = 1'b1; present[8'h78] = 1'b1; present[8'h7F] = 1'b1;
    run_sweep(1'b0);
    check(map_o === expect_map(present), "R6 sparse map", map_o, expect_map(present));
    check(map_o[0] === 1'b0 && map_o[127:120] === 8'h00, "R7 unprobed bits",
          {map_o[127:120], map_o[0]}, '0);
    check_bus("sparse");
  endtask

  task automatic t_none();
    present = '0;
    run_sweep(1'b0);
    check(map_o === '0, "R6 empty bus map", map_o, '0);
    check_bus("empty");
  endtask

  task automatic t_all_busy_poke();
    present = '1;
    run_sweep(1'b1);
    check(map_o === expect_map(present), "R10 full map after ignored start", map_o,
          expect_map(present));
    check(probe_cnt == NPROBES && order_err == 0, "R10 sweep not restarted",
          128'(probe_cnt), 128'(NPROBES));
    check(map_o[127:120] === 8'h00, "R7 top byte with all responding",
          128'(map_o[127:120]), '0);
  endtask

  task automatic t_hold();
    logic [127:0] snap;
    snap = map_o;
    present = '0;
    repeat (2000) @(negedge clk);
    check(map_o === snap, "R9 map holds while idle", map_o, snap);
    check(scl_oe_o === 1'b0 && sda_oe_o === 1'b0 && busy_o === 1'b0,
          "R1 idle lines released", {busy_o, scl_oe_o, sda_oe_o}, '0);
  endtask

  initial begin
    clear_monitor();
    fork
      begin
        t_reset();
        t_sparse();
        t_hold();
        t_none();
        t_all_busy_poke();
        t_hold();
      end
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule